// File: doc/BRIEF.md
# Indexed Block-Transfer Control Register Slave

This block is a two-wire serial slave with a bank of eight 8-bit control registers. Those registers drive the clock-control logic of a timing chip. A host writes the bank and reads it back with indexed block transfers. SDA and SCL arrive as open-drain lines and are sampled by the system clock. The block pulls SDA low through a single enable output. Every register is also brought out in parallel as a flat registered vector.

A write transfer has this order: the write address byte, a start index, a byte count, then the data bytes, which land in consecutive registers. A read transfer sends the write address and an index. The host then issues a repeated START and the read address. The slave answers with a count byte first and then the register contents from the chosen index onward. The register index wraps from the last register back to register 0. Register 7 is read-only and holds a revision nibble and a fixed vendor nibble. Reserved bits elsewhere ignore writes.

Top module: `smb_regbank`

## Requirements
- R1: After reset the registers read 0xFF, 0xFE, 0x65, 0x0F, 0x80, 0x00, 0x00 and {REV_ID,4'b0001} for indices 0 to 7. Register 2 bit 0 is the hardware or register stop-source select and resets to 1.
- R2: The slave acknowledges an address byte of 0xD2 (write) or 0xD3 (read) by pulling SDA low in the ninth clock. Any other address gets no acknowledge, and SDA stays released until the next START.
- R3: In a write, the byte after the address sets the start index N and the next byte sets the count X. Each byte is acknowledged, and the following X data bytes are acknowledged and stored in registers N to N+X-1.
- R4: Data bytes beyond the count X are not acknowledged and are not stored.
- R5: The register index advances by one after every data byte and wraps from 7 to 0, on writes and on reads.
- R6: Register 7 ignores writes. Bits outside the writable masks (0xE5 for register 2, 0xE0 for register 4, none for registers 5 and 6) keep their value. Registers 0, 1 and 3 are fully writable.
- R7: After a repeated START with address 0xD3, the slave sends a count byte equal to the register count (8). It then sends the registers starting at the last index written, most significant bit first.
- R8: When the host does not acknowledge a read byte, the slave releases SDA and drives nothing more until the next START.
- R9: A START at any point restarts the address phase. A STOP returns the slave to idle.
- R10: The slave starts pulling SDA low only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| regs_o | output | NUM_REGS*8 | All registers, register i in bits [8*i+7:8*i] |

## Verification
Each line passes through two synchroniser flops and an edge flop before the state machine sees it, and the response is registered once more. SDA therefore answers a falling SCL about four system clocks later. The bench holds every SCL phase for eight clocks. It sets data or samples the line only in the middle of a phase, well after that delay. A stored register changes one clock after its acknowledge is driven, so the register image is compared only after the STOP that closes a transfer. Acknowledge bits, returned read bytes and register images all go through one expected-value queue that is drained in order.

// File: rtl/smb_pkg.sv
package smb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_RX_ACK, ST_TX, ST_TX_ACK, ST_SKIP
  } link_state_e;

  typedef enum logic [1:0] {
    PH_ADDR, PH_INDEX, PH_COUNT, PH_DATA
  } phase_e;

  function automatic logic [7:0] reg_reset(input int unsigned i, input logic [3:0] rev);
    case (i)
      0: return 8'hFF;
      1: return 8'hFE;
      2: return 8'h65;
      3: return 8'h0F;
      4: return 8'h80;
      7: return {rev, 4'b0001};
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] reg_wmask(input int unsigned i);
    case (i)
      0: return 8'hFF;
      1: return 8'hFF;
      2: return 8'hE5;
      3: return 8'hFF;
      4: return 8'hE0;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_prev, sda_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_prev <= scl_pipe[STAGES-1];
      sda_prev <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_prev;
  assign scl_fall  = ~scl_s & scl_prev;
  assign start_det = scl_s & scl_prev & sda_prev & ~sda_s;
  assign stop_det  = scl_s & scl_prev & ~sda_prev & sda_s;
endmodule

// File: rtl/smb_link.sv
module smb_link
  import smb_pkg::*;
#(
  parameter int         NUM_REGS = 8,
  parameter logic [6:0] DEV_ADDR = 7'h69,
  localparam int        IDXW     = $clog2(NUM_REGS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sda_s,
  input  logic            scl_rise,
  input  logic            scl_fall,
  input  logic            start_det,
  input  logic            stop_det,
  input  logic [7:0]      rd_data,
  output logic [IDXW-1:0] rd_idx,
  output logic            sda_oe,
  output logic            wr_en,
  output logic [IDXW-1:0] wr_idx,
  output logic [7:0]      wr_data,
  output link_state_e     state_o
);
  localparam logic [7:0] COUNT_BYTE = 8'(NUM_REGS);

  link_state_e     state;
  phase_e          phase;
  logic [3:0]      bitcnt;
  logic [7:0]      shreg, tx_sh, left;
  logic [IDXW-1:0] idx;
  logic            rd_mode, mack_seen, host_ack;

  always_ff @(posedge clk) begin
    wr_en <= 1'b0;
    if (rst) begin
      state     <= ST_IDLE;
      phase     <= PH_ADDR;
      bitcnt    <= '0;
      shreg     <= '0;
      tx_sh     <= '0;
      left      <= '0;
      idx       <= '0;
      rd_mode   <= 1'b0;
      mack_seen <= 1'b0;
      host_ack  <= 1'b0;
      sda_oe    <= 1'b0;
      wr_idx    <= '0;
      wr_data   <= '0;
    end else if (start_det) begin
      state  <= ST_RX;
      phase  <= PH_ADDR;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else if (stop_det) begin
      state  <= ST_IDLE;
      sda_oe <= 1'b0;
    end else begin
      case (state)
        ST_RX: begin
          if (scl_rise) begin
            shreg  <= {shreg[6:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_fall && bitcnt == 4'd8) begin
            bitcnt <= '0;
            state  <= ST_RX_ACK;
            case (phase)
              PH_ADDR: begin
                if (shreg[7:1] == DEV_ADDR) begin
                  sda_oe  <= 1'b1;
                  rd_mode <= shreg[0];
                  phase   <= PH_INDEX;
                end else begin
                  state <= ST_SKIP;
                end
              end
              PH_INDEX: begin
                idx    <= shreg[IDXW-1:0];
                sda_oe <= 1'b1;
                phase  <= PH_COUNT;
              end
              PH_COUNT: begin
                left   <= shreg;
                sda_oe <= 1'b1;
                phase  <= PH_DATA;
              end
              default: begin
                if (left != 8'd0) begin
                  wr_en   <= 1'b1;
                  wr_idx  <= idx;
                  wr_data <= shreg;
                  idx     <= idx + 1'b1;
                  left    <= left - 8'd1;
                  sda_oe  <= 1'b1;
                end
              end
            endcase
          end
        end
        ST_RX_ACK: begin
          if (scl_fall) begin
            if (rd_mode) begin
              tx_sh  <= COUNT_BYTE;
              sda_oe <= ~COUNT_BYTE[7];
              state  <= ST_TX;
            end else begin
              sda_oe <= 1'b0;
              state  <= ST_RX;
            end
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_fall) begin
            if (bitcnt == 4'd8) begin
              sda_oe    <= 1'b0;
              mack_seen <= 1'b0;
              state     <= ST_TX_ACK;
            end else begin
              tx_sh  <= {tx_sh[6:0], 1'b0};
              sda_oe <= ~tx_sh[6];
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise) begin
            mack_seen <= 1'b1;
            host_ack  <= ~sda_s;
          end else if (scl_fall && mack_seen) begin
            if (host_ack) begin
              tx_sh  <= rd_data;
              sda_oe <= ~rd_data[7];
              idx    <= idx + 1'b1;
              bitcnt <= '0;
              state  <= ST_TX;
            end else begin
              state <= ST_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign rd_idx  = idx;
  assign state_o = state;
endmodule

// File: rtl/smb_regfile.sv
module smb_regfile
  import smb_pkg::*;
#(
  parameter int         NUM_REGS = 8,
  parameter logic [3:0] REV_ID   = 4'h3,
  localparam int        IDXW     = $clog2(NUM_REGS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [IDXW-1:0]       wr_idx,
  input  logic [7:0]            wr_data,
  input  logic [IDXW-1:0]       rd_idx,
  output logic [7:0]            rd_data,
  output logic [NUM_REGS*8-1:0] regs_o
);
  logic [7:0] regs [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam logic [7:0] RST_V = reg_reset(i, REV_ID);
    localparam logic [7:0] MASK  = reg_wmask(i);
    always_ff @(posedge clk) begin
      if (rst)
        regs[i] <= RST_V;
      else if (wr_en && wr_idx == IDXW'(i))
        regs[i] <= (regs[i] & ~MASK) | (wr_data & MASK);
    end
    assign regs_o[8*i +: 8] = regs[i];
  end

  assign rd_data = regs[rd_idx];
endmodule

// File: rtl/smb_regbank.sv
module smb_regbank
  import smb_pkg::*;
#(
  parameter int         NUM_REGS = 8,
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter logic [3:0] REV_ID   = 4'h3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe,
  output logic [NUM_REGS*8-1:0] regs_o
);
  localparam int IDXW = $clog2(NUM_REGS);

  logic            scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic            wr_en;
  logic [IDXW-1:0] wr_idx, rd_idx;
  logic [7:0]      wr_data, rd_data;
  link_state_e     lk_state;

  smb_line_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  smb_link #(.NUM_REGS(NUM_REGS), .DEV_ADDR(DEV_ADDR)) u_link (
    .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .rd_data(rd_data), .rd_idx(rd_idx),
    .sda_oe(sda_oe), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .state_o(lk_state)
  );

  smb_regfile #(.NUM_REGS(NUM_REGS), .REV_ID(REV_ID)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rd_data), .regs_o(regs_o)
  );
endmodule

// File: rtl/smb_regbank_chk.sv
module smb_regbank_chk
  import smb_pkg::*;
#(
  parameter int         NUM_REGS = 8,
  parameter logic [3:0] REV_ID   = 4'h3
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  scl_s,
  input logic                  sda_oe,
  input logic                  wr_en,
  input link_state_e           lk_state,
  input logic [NUM_REGS*8-1:0] regs_o
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_rst
    AST_RESET_IMAGE: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> regs_o[8*i +: 8] == reg_reset(i, REV_ID)); // R1
  end

  AST_QUIET_WHEN_UNSELECTED: assert property (@(posedge clk) disable iff (rst)
    (lk_state == ST_IDLE || lk_state == ST_SKIP) |-> !sda_oe); // R8

  AST_PULL_ONLY_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    (sda_oe && !$past(sda_oe)) |-> !scl_s); // R10

  AST_STORE_IS_ACKED: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> sda_oe); // R3
endmodule

bind smb_regbank smb_regbank_chk #(.NUM_REGS(NUM_REGS), .REV_ID(REV_ID)) u_chk (
  .clk(clk), .rst(rst), .scl_s(scl_s), .sda_oe(sda_oe), .wr_en(wr_en),
  .lk_state(lk_state), .regs_o(regs_o)
);

// File: tb/smb_regbank_tb.sv
module smb_regbank_tb_top;
  localparam int NR = 8;
  localparam int Q  = 8;

  typedef struct {
    string      tag;
    logic [7:0] val;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_oe;
  logic [NR*8-1:0] regs_o;
  logic sda_line;

  exp_t       exp_q[$];
  logic [7:0] act_q[$];
  int         n_vec = 0;
  int         n_bad = 0;
  logic [7:0] model [NR];

  assign sda_line = m_sda & ~sda_oe;

  always #10 clk = ~clk;

  smb_regbank #(.NUM_REGS(NR), .DEV_ADDR(7'h69), .REV_ID(4'h3)) dut_i (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .regs_o(regs_o)
  );

  // monitor: pops actual items and compares them against the expected queue
  always @(negedge clk) begin
    while (act_q.size() > 0) begin
      automatic logic [7:0] a = act_q.pop_front();
      n_vec++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL unexpected item actual %h expected none", a);
      end else begin
        automatic exp_t e = exp_q.pop_front();
        if (a !== e.val) begin
          n_bad++;
          $display("FAIL %s actual %h expected %h", e.tag, a, e.val);
        end
      end
    end
  end

  task automatic wq(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_item(string tag, logic [7:0] v);
    exp_q.push_back('{tag, v});
  endtask

  task automatic do_start();
    m_sda = 1'b1; wq(Q);
    scl = 1'b1;   wq(Q);
    m_sda = 1'b0; wq(Q);
    scl = 1'b0;   wq(Q);
  endtask

  task automatic do_stop();
    m_sda = 1'b0; wq(Q);
    scl = 1'b1;   wq(Q);
    m_sda = 1'b1; wq(Q);
  endtask

  task automatic clock_bit(input logic b, output logic s);
    m_sda = b; wq(Q);
    scl = 1'b1; wq(Q);
    s = sda_line; wq(Q);
    scl = 1'b0; wq(Q);
  endtask

  task automatic send_byte(logic [7:0] b, string tag, logic exp_nack);
    logic s;
    for (int i = 7; i >= 0; i--) clock_bit(b[i], s);
    clock_bit(1'b1, s);
    m_sda = 1'b1;
    expect_item(tag, {7'd0, exp_nack});
    act_q.push_back({7'd0, s});
  endtask

  task automatic recv_byte(logic host_ack, string tag, logic [7:0] ev);
    logic s;
    logic [7:0] b;
    for (int i = 7; i >= 0; i--) begin
      clock_bit(1'b1, s);
      b[i] = s;
    end
    clock_bit(~host_ack, s);
    m_sda = 1'b1;
    expect_item(tag, ev);
    act_q.push_back(b);
  endtask

  task automatic check_image(string tag);
    wq(4);
    for (int i = 0; i < NR; i++) begin
      expect_item(tag, model[i]);
      act_q.push_back(regs_o[8*i +: 8]);
    end
    wq(2);
  endtask

  task automatic block_write(logic [7:0] n, logic [7:0] x, logic [7:0] d[$], string tag);
    do_start();
    send_byte(8'hD2, "R2 write address ack", 1'b0);
    send_byte(n, "R3 index ack", 1'b0);
    send_byte(x, "R3 count ack", 1'b0);
    foreach (d[k]) send_byte(d[k], tag, (k >= x));
    do_stop();
  endtask

  task automatic block_read(logic [7:0] n, int nbytes, string tag);
    do_start();
    send_byte(8'hD2, "R2 write address ack", 1'b0);
    send_byte(n, "R3 index ack", 1'b0);
    do_start();
    send_byte(8'hD3, "R2 read address ack", 1'b0);
    recv_byte(1'b1, "R7 count byte", 8'(NR));
    for (int k = 0; k < nbytes; k++)
      recv_byte(k != nbytes - 1, tag, model[(int'(n) + k) % NR]);
    // R8: after the host NACK the slave must leave SDA released
    recv_byte(1'b0, "R8 released after host NACK", 8'hFF);
    do_stop();
  endtask

  initial begin
    model = '{8'hFF, 8'hFE, 8'h65, 8'h0F, 8'h80, 8'h00, 8'h00, 8'h31};
    wq(5);
    rst = 1'b0;
    wq(4);
    check_image("R1 reset image");

    // R3: two bytes into registers 1 and 2 (register 2 mask 0xE5)
    block_write(8'd1, 8'd2, '{8'hAA, 8'h55}, "R3 data ack");
    model[1] = 8'hAA; model[2] = 8'h45;
    check_image("R3 block write");

    // R5 and R6: start at 6, wrap into 0; registers 6 and 7 keep their value
    block_write(8'd6, 8'd3, '{8'h11, 8'h22, 8'h33}, "R5 wrap data ack");
    model[0] = 8'h33;
    check_image("R5 R6 wrap and read-only");

    // R4: second byte exceeds count 1
    block_write(8'd3, 8'd1, '{8'h5A, 8'hA5}, "R4 data ack or nack");
    model[3] = 8'h5A;
    check_image("R4 beyond count not stored");

    // R6: register 4 keeps its reserved low bits
    block_write(8'd4, 8'd1, '{8'hFF}, "R6 data ack");
    model[4] = 8'hE0;
    check_image("R6 reserved bits");

    // R2: foreign address, no ack, SDA stays released
    do_start();
    send_byte(8'hA4, "R2 foreign address nack", 1'b1);
    send_byte(8'h77, "R2 released after mismatch", 1'b1);
    do_stop();
    check_image("R2 no change on mismatch");

    // R7: read everything from index 0
    block_read(8'd0, NR, "R7 read data");
    // R5: read wrap from index 6
    block_read(8'd6, 3, "R5 read wrap data");

    // R9: restart in the middle of a write
    do_start();
    send_byte(8'hD2, "R9 address ack", 1'b0);
    send_byte(8'd5, "R9 index ack", 1'b0);
    do_start();
    send_byte(8'hD2, "R9 restart address ack", 1'b0);
    send_byte(8'd0, "R9 index ack", 1'b0);
    send_byte(8'd1, "R9 count ack", 1'b0);
    send_byte(8'h12, "R9 data ack", 1'b0);
    do_stop();
    model[0] = 8'h12;
    check_image("R9 restart");

    wq(4);
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL missing items actual %0d expected 0", exp_q.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule